// File: doc/BRIEF.md
# Frame-Synchronised Multi-Lane Serial Readout

This block sends the eight conversion results of a four-pair sampling converter out through a serial port. A host starts a frame by pulling the active-low frame-sync input low. From then on every falling edge of the serial clock moves each active output lane on by one bit. Each result word goes out most significant bit first. Two select inputs decide whether the results share one lane, are split over two lanes, or go one pair per lane.

When the daisy-chain enable is set, a lane first sends its local words. After that it forwards the bits arriving on its chain input from an upstream device, one bit per serial clock falling edge. The readout position is kept across frames, so a host can read the results in several short frames. A rising edge on the pair-A start input rewinds the readout to channel A0.

All control inputs are sampled by the block's own clock, and edges are detected in that domain. The select lines and the chain enable are captured when a frame opens. Each lane has a data output and an output-enable output, which together form a tri-state lane.

Top module: `frame_serial_readout`

## Requirements
- R1: While frame sync is high, and after reset, every lane output enable is low and every lane data output is 0.
- R2: On the clock after a falling edge of frame sync, each active lane is enabled and drives the MSB of the word at the current readout position.
- R3: Each falling edge of the serial clock inside a frame moves every active lane on by one bit, MSB first. Between such edges the lane data holds, as long as the result inputs hold.
- R4: Channel k (0..7, in the order A0, A1, B0, B1, C0, C1, D0, D1) takes bits [16k+15:16k] of the results bus. With both selects low, lane 0 sends channels 0 to 7 in order, and lanes 1 to 3 are disabled.
- R5: With the two-lane select high and the four-lane select low, lane 0 sends A0, A1, C0, C1 and lane 1 sends B0, B1, D0, D1. Lanes 2 and 3 are disabled.
- R6: With the four-lane select high, lane i (0..3) sends only channels 2i and 2i+1, and all four lanes are enabled.
- R7: The readout position survives the end of a frame. A word that was fully shifted is not sent again. A word that was cut off when the frame closed restarts from its MSB in the next frame.
- R8: A rising edge on the pair-A start input returns the readout position to the first word of every lane.
- R9: Once a lane has sent all its local words, and daisy-chain is off for that lane, it drives 0 for the rest of the frame.
- R10: With daisy-chain on, after the local words a lane drives its chain input bit, sampled at the latest serial clock falling edge (or at frame open). Lane 0 uses its chain input always, lane 1 only when the two-lane select was high, and lanes 2 and 3 only when the four-lane select was high. Otherwise the lane drives 0.
- R11: The select lines and the chain enable are captured at the frame-sync falling edge. Changing them during the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; its falling edge advances the lanes |
| fs_n | input | 1 | Active-low frame sync |
| conv_a | input | 1 | Pair-A conversion start; its rising edge rewinds the readout |
| sel_b | input | 1 | Two-lane layout select |
| sel_cd | input | 1 | Four-lane layout select (takes priority over sel_b) |
| chain_en | input | 1 | Daisy-chain forwarding enable |
| chain_in | input | 4 | Per-lane serial input from the upstream device |
| results | input | 8*WORD_W | Eight result words, channel k at bits [WORD_W*k +: WORD_W] |
| lane_data | output | 4 | Serial data of each lane |
| lane_oe | output | 4 | Output enable of each lane (low means high impedance) |

## Verification
The main function is tried in all three layouts, with result words that differ in every nibble, so a wrong channel order or a wrong lane assignment shows up as a bit mismatch. Frames are run past the end of the local words with chain forwarding off and on, and with the chain inputs changing on every bit. This tells zero fill apart from forwarding, and it shows that lane 1's chain input is ignored in the four-lane layout when the two-lane select is low. The selects are flipped in the middle of a frame to show they are captured at frame open. Short frames that close partway through a word, plus a rewind pulse between frames, tell a resumed readout apart from a restarted one.

// File: rtl/frame_readout_pkg.sv
package frame_readout_pkg;

    // How the eight channel results are spread across the output lanes.
    typedef enum logic [1:0] {
        LAYOUT_ONE  = 2'd0,
        LAYOUT_TWO  = 2'd1,
        LAYOUT_FOUR = 2'd2
    } layout_e;

    localparam int NUM_LANES = 4;
    localparam int NUM_CH    = 2 * NUM_LANES;

endpackage

// File: rtl/frame_input_history.sv
module frame_input_history #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] prev
);

    logic [W-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= RST_VAL;
        else        hist_q <= hist_d;
    end

    assign prev = hist_q;

endmodule

// File: rtl/frame_lane_select.sv
module frame_lane_select
    import frame_readout_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LANE   = 0,
    parameter int WIDX_W = 4,
    parameter int BIT_W  = 4
) (
    input  layout_e                  layout,
    input  logic [WIDX_W-1:0]        word,
    input  logic [WIDX_W-1:0]        words,
    input  logic [BIT_W-1:0]         bit_idx,
    input  logic [NUM_CH*WORD_W-1:0] results,
    input  logic                     open,
    input  logic                     chain_bit,
    input  logic                     chain_ok,
    output logic                     oe,
    output logic                     data
);

    localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(WORD_W - 1);

    logic [WORD_W-1:0]         ch_word [NUM_CH];
    logic [1:0]                pair;
    logic [$clog2(NUM_CH)-1:0] ch;
    logic [WORD_W-1:0]         cur;
    logic [BIT_W-1:0]          pos;
    logic                      active;
    logic                      local_phase;

    always_comb begin
        for (int k = 0; k < NUM_CH; k++) begin
            ch_word[k] = results[k*WORD_W +: WORD_W];
        end
        case (layout)
            LAYOUT_ONE: pair = word[2:1];
            LAYOUT_TWO: pair = {word[1], 1'b0} | 2'(LANE);
            default:    pair = 2'(LANE);
        endcase
        ch          = {pair, word[0]};
        cur         = ch_word[ch];
        pos         = BIT_TOP - bit_idx;
        active      = (LANE == 0) || (layout == LAYOUT_FOUR) ||
                      ((LANE == 1) && (layout == LAYOUT_TWO));
        local_phase = (word < words);
        oe          = open && active;
        if (!oe)              data = 1'b0;
        else if (local_phase) data = cur[pos];
        else                  data = chain_ok && chain_bit;
    end

endmodule

// File: rtl/frame_serial_readout.sv
module frame_serial_readout
    import frame_readout_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk,
    input  logic                     fs_n,
    input  logic                     conv_a,
    input  logic                     sel_b,
    input  logic                     sel_cd,
    input  logic                     chain_en,
    input  logic [NUM_LANES-1:0]     chain_in,
    input  logic [NUM_CH*WORD_W-1:0] results,
    output logic [NUM_LANES-1:0]     lane_data,
    output logic [NUM_LANES-1:0]     lane_oe
);

    localparam int BIT_W  = $clog2(WORD_W);
    localparam int WIDX_W = $clog2(NUM_CH + 1);
    localparam logic [BIT_W-1:0]  BIT_LAST   = BIT_W'(WORD_W - 1);
    localparam logic [WIDX_W-1:0] WORDS_ONE  = WIDX_W'(NUM_CH);
    localparam logic [WIDX_W-1:0] WORDS_TWO  = WIDX_W'(NUM_CH / 2);
    localparam logic [WIDX_W-1:0] WORDS_FOUR = WIDX_W'(NUM_CH / NUM_LANES);

    typedef struct packed {
        logic                  open;
        logic [BIT_W-1:0]      bit_idx;
        logic [WIDX_W-1:0]     word;
        layout_e               layout;
        logic                  sel_b;
        logic                  chain_en;
        logic [NUM_LANES-1:0]  chain;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        open: 1'b0, bit_idx: '0, word: '0, layout: LAYOUT_ONE,
        sel_b: 1'b0, chain_en: 1'b0, chain: '0
    };

    // Input history: {conv_a, fs_n, sclk}
    logic [2:0] in_prev;

    frame_input_history #(.W(3), .RST_VAL(3'b011)) hist_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({conv_a, fs_n, sclk}),
        .prev  (in_prev)
    );

    logic sclk_fall, fs_fall, conv_rise, advance;
    logic [WIDX_W-1:0] words;
    seq_t seq_d, seq_q;

    always_comb begin
        sclk_fall = in_prev[0] && !sclk;
        fs_fall   = in_prev[1] && !fs_n;
        conv_rise = !in_prev[2] && conv_a;
        advance   = sclk_fall && seq_q.open && !fs_n && !fs_fall;
        case (seq_q.layout)
            LAYOUT_ONE: words = WORDS_ONE;
            LAYOUT_TWO: words = WORDS_TWO;
            default:    words = WORDS_FOUR;
        endcase

        seq_d = seq_q;
        if (fs_fall) begin
            seq_d.open     = 1'b1;
            seq_d.bit_idx  = '0;
            seq_d.layout   = sel_cd ? LAYOUT_FOUR : (sel_b ? LAYOUT_TWO : LAYOUT_ONE);
            seq_d.sel_b    = sel_b;
            seq_d.chain_en = chain_en;
            seq_d.chain    = chain_in;
        end else if (fs_n) begin
            seq_d.open = 1'b0;
        end

        if (conv_rise) begin
            seq_d.word    = '0;
            seq_d.bit_idx = '0;
        end else if (advance) begin
            seq_d.chain = chain_in;
            if (seq_q.word < words) begin
                if (seq_q.bit_idx == BIT_LAST) begin
                    seq_d.bit_idx = '0;
                    seq_d.word    = seq_q.word + 1'b1;
                end else begin
                    seq_d.bit_idx = seq_q.bit_idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            logic chain_ok;
            if (g == 0) begin : g_ok0
                assign chain_ok = seq_q.chain_en;
            end else if (g == 1) begin : g_ok1
                assign chain_ok = seq_q.chain_en && seq_q.sel_b;
            end else begin : g_okn
                assign chain_ok = seq_q.chain_en && (seq_q.layout == LAYOUT_FOUR);
            end

            frame_lane_select #(
                .WORD_W (WORD_W),
                .LANE   (g),
                .WIDX_W (WIDX_W),
                .BIT_W  (BIT_W)
            ) lane_i (
                .layout    (seq_q.layout),
                .word      (seq_q.word),
                .words     (words),
                .bit_idx   (seq_q.bit_idx),
                .results   (results),
                .open      (seq_q.open),
                .chain_bit (seq_q.chain[g]),
                .chain_ok  (chain_ok),
                .oe        (lane_oe[g]),
                .data      (lane_data[g])
            );
        end
    endgenerate

endmodule

// File: rtl/frame_serial_readout_chk.sv
module frame_serial_readout_chk #(
    parameter int WORD_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sclk,
    input logic                fs_n,
    input logic                conv_a,
    input logic [8*WORD_W-1:0] results,
    input logic [3:0]          lane_data,
    input logic [3:0]          lane_oe
);

    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fs_n) |-> (lane_oe == 4'b0000 && lane_data == 4'b0000));

    assert_frame_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fs_n) && !fs_n) |=> lane_oe[0]);

    assert_hold_between_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_oe[0] && $past(lane_oe[0]) && !$past(fs_n) && !$past(fs_n, 2) &&
         !($past(sclk, 2) && !$past(sclk)) && !(!$past(conv_a, 2) && $past(conv_a)) &&
         $stable(results)) |-> $stable(lane_data));

    assert_two_lane_needs_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lane_oe[1] |-> lane_oe[0]);

    assert_four_lanes_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_oe[2] || lane_oe[3]) |-> (lane_oe == 4'b1111));

endmodule

bind frame_serial_readout frame_serial_readout_chk #(.WORD_W(WORD_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .fs_n      (fs_n),
    .conv_a    (conv_a),
    .results   (results),
    .lane_data (lane_data),
    .lane_oe   (lane_oe)
);

// File: tb/frame_serial_readout_tb.sv
`timescale 1ns/1ps
module frame_serial_readout_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b1;
    logic         fs_n = 1'b1;
    logic         conv_a = 1'b0;
    logic         sel_b = 1'b0;
    logic         sel_cd = 1'b0;
    logic         chain_en = 1'b0;
    logic [3:0]   chain_in = 4'b0000;
    logic [127:0] results = '0;
    logic [3:0]   lane_data;
    logic [3:0]   lane_oe;

    int    checks = 0;
    int    errors = 0;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    frame_serial_readout #(.WORD_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .fs_n(fs_n), .conv_a(conv_a),
        .sel_b(sel_b), .sel_cd(sel_cd), .chain_en(chain_en), .chain_in(chain_in),
        .results(results), .lane_data(lane_data), .lane_oe(lane_oe)
    );

    // Behavioural reference model
    bit m_open;
    int m_word, m_bit;
    bit [3:0] m_chain;
    bit m_selb, m_selcd, m_chen;
    int lane_len [4];
    int lane_ch  [4][8];
    bit p_fs, p_sclk, p_cv;

    function automatic void build_lists(bit sb, bit scd);
        for (int i = 0; i < 4; i++) lane_len[i] = 0;
        if (scd) begin
            for (int i = 0; i < 4; i++) begin
                lane_len[i] = 2; lane_ch[i][0] = 2*i; lane_ch[i][1] = 2*i + 1;
            end
        end else if (sb) begin
            lane_len[0] = 4; lane_len[1] = 4;
            lane_ch[0][0] = 0; lane_ch[0][1] = 1; lane_ch[0][2] = 4; lane_ch[0][3] = 5;
            lane_ch[1][0] = 2; lane_ch[1][1] = 3; lane_ch[1][2] = 6; lane_ch[1][3] = 7;
        end else begin
            lane_len[0] = 8;
            for (int k = 0; k < 8; k++) lane_ch[0][k] = k;
        end
    endfunction

    function automatic bit chain_allowed(int i);
        if (i == 0) return m_chen;
        if (i == 1) return m_chen && m_selb;
        return m_chen && m_selcd;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_open = 0; m_word = 0; m_bit = 0; m_chain = 0;
            m_selb = 0; m_selcd = 0; m_chen = 0;
            p_fs = 1; p_sclk = 1; p_cv = 0;
            build_lists(0, 0);
        end else begin
            bit ffall, sfall, crise, adv;
            ffall = p_fs && !fs_n;
            sfall = p_sclk && !sclk;
            crise = !p_cv && conv_a;
            adv   = sfall && m_open && !fs_n && !ffall;
            if (ffall) begin
                m_open = 1; m_bit = 0;
                m_selb = sel_b; m_selcd = sel_cd; m_chen = chain_en;
                m_chain = chain_in;
                build_lists(sel_b, sel_cd);
            end else if (fs_n) begin
                m_open = 0;
            end
            if (crise) begin
                m_word = 0; m_bit = 0;
            end else if (adv) begin
                m_chain = chain_in;
                if (m_word < lane_len[0]) begin
                    if (m_bit == 15) begin m_bit = 0; m_word++; end
                    else m_bit++;
                end
            end
            p_fs = fs_n; p_sclk = sclk; p_cv = conv_a;
        end
    end

    always @(negedge clk) begin
        if (checking && !done) begin
            logic [3:0] e_oe, e_d;
            logic [15:0] w;
            e_oe = '0; e_d = '0;
            for (int i = 0; i < 4; i++) begin
                if (m_open && lane_len[i] > 0) begin
                    e_oe[i] = 1'b1;
                    if (m_word < lane_len[i]) begin
                        w = results[lane_ch[i][m_word]*16 +: 16];
                        e_d[i] = w[15 - m_bit];
                    end else begin
                        e_d[i] = chain_allowed(i) && m_chain[i];
                    end
                end
            end
            checks++;
            if (lane_oe !== e_oe || lane_data !== e_d) begin
                errors++;
                $display("FAIL %s: oe=%b data=%b expected oe=%b data=%b at %0t",
                         cur_req, lane_oe, lane_data, e_oe, e_d, $time);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulses(int n);
        for (int k = 0; k < n; k++) begin
            sclk = 1'b0; cyc(2);
            sclk = 1'b1; cyc(2);
        end
    endtask

    task automatic chain_pulses(int n);
        for (int k = 0; k < n; k++) begin
            chain_in = 4'((k * 5 + 3) ^ (k >> 1));
            sclk = 1'b0; cyc(2);
            sclk = 1'b1; cyc(2);
        end
    endtask

    task automatic open_frame(bit sb, bit scd, bit ce);
        sel_b = sb; sel_cd = scd; chain_en = ce;
        fs_n = 1'b0; cyc(2);
    endtask

    task automatic close_frame();
        fs_n = 1'b1; cyc(3);
    endtask

    task automatic rewind();
        conv_a = 1'b1; cyc(2);
        conv_a = 1'b0; cyc(2);
    endtask

    task automatic set_results(int seed);
        for (int k = 0; k < 8; k++) begin
            results[k*16 +: 16] = 16'((k + 1) * 16'h1357) ^ 16'(seed * 16'h2C91) ^ 16'hA5C3;
        end
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        checking = 1'b1;
        cur_req = "R1"; cyc(4);                      // reset / idle state

        // One-lane layout, chain off
        set_results(1);
        cur_req = "R8"; rewind();
        cur_req = "R2"; open_frame(0, 0, 0);
        cur_req = "R3"; pulses(16);
        cur_req = "R4"; pulses(112);
        cur_req = "R9"; pulses(6);
        cur_req = "R1"; close_frame();

        // Two-lane layout with forwarding, selects changed mid-frame
        set_results(2);
        rewind();
        chain_in = 4'b0101;
        cur_req = "R5"; open_frame(1, 0, 1);
        pulses(32);
        cur_req = "R11"; sel_b = 1'b0; sel_cd = 1'b1; chain_en = 1'b0;
        pulses(32);
        cur_req = "R10"; chain_pulses(8);
        close_frame();

        // Four-lane layout, lane 1 forwarding disallowed
        set_results(3);
        rewind();
        cur_req = "R6"; open_frame(0, 1, 1);
        pulses(32);
        cur_req = "R10"; chain_pulses(8);
        close_frame();

        // Readout position across frames, then rewind
        set_results(4);
        rewind();
        cur_req = "R7"; open_frame(0, 0, 0);
        pulses(20); close_frame();
        open_frame(0, 0, 0); pulses(16); close_frame();
        open_frame(0, 0, 0); pulses(4); close_frame();
        cur_req = "R8"; rewind();
        open_frame(0, 0, 0); pulses(20); close_frame();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule